// File: doc/BRIEF.md
# Temperature Monitor Node Controller

This block is the application-level controller of an engine-temperature node that sits on a shared, identifier-addressed message bus. Bus framing is handled elsewhere. The controller sees each received message as an identifier, a remote-request flag and a valid strobe. It sends its own messages as a valid/ready stream of identifier plus one payload byte. After reset the node is dormant. It answers nothing and does not sample until an activation message arrives.

Once active, the node starts a conversion on an external 8-bit ADC at a fixed tick interval, using a one-cycle start pulse. It latches the byte when the converter signals done. A reading above the on-threshold produces an over-temperature message once per rising crossing. The node also drives a hysteretic cooling output and reports when that output switches on. Remote requests for the dashboard reading and the cooling reading are answered with the latest sample. A deactivate-all message returns the node to dormant.

Message identifiers are consecutive. Message number k is sent with identifier `ID_BASE + k - 1`. Activation is number 1, over-temperature number 4, cooling-on status number 5, dashboard reading number 8, cooling reading number 9 and deactivate-all number 11. The sensor scales at 10 mV per degree, so with a 5 V reference code 36 is about 70 degrees and code 31 is about 60 degrees.

Top module: `tmon_node`

## Requirements
- R1: While dormant (after reset, or after deactivation), the node issues no ADC start and no new transmit message, and the cooling output stays low, whatever other messages arrive.
- R2: A data frame (rx_remote = 0) with identifier number 1 makes the node active, and node_active goes high.
- R3: While active, adc_start is a single-cycle pulse issued every SAMPLE_TICKS cycles. A reading is taken only from adc_data in a cycle where adc_done is high.
- R4: A reading strictly above ON_CODE while armed sends message number 4, carrying that reading, and disarms. The node re-arms only after a reading strictly below OFF_CODE.
- R5: The cooling output switches on on an over-temperature event, or on a received data frame with number 4 while active. Each off-to-on switch sends message number 5 with payload 0x01.
- R6: A reading strictly below OFF_CODE switches cooling off. Readings from OFF_CODE to ON_CODE leave it unchanged.
- R7: A remote frame with number 8 while active is answered with message number 8 carrying the latest reading. A data frame with number 8 gets no answer.
- R8: A remote frame with number 9 while active is answered with message number 9 carrying the latest reading.
- R9: Once tx_valid is high, tx_id and tx_data stay stable and tx_valid stays high until a cycle with tx_ready high.
- R10: When several messages are waiting, they leave in ascending identifier order (4, 5, 8, 9). A message already on the port is never replaced.
- R11: A data frame with number 11 makes the node dormant. It clears cooling, queued messages and the latest reading (to 0), and re-arms the over-temperature detector. A message already on the port still completes.
- R12: rx_ready is always high. Every presented message is consumed in its valid cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received message present |
| rx_ready | output | 1 | Always high; no back-pressure on receive |
| rx_id | input | ID_W | Received identifier |
| rx_remote | input | 1 | 1 = remote request, 0 = data frame |
| adc_start | output | 1 | One-cycle conversion start |
| adc_done | input | 1 | Conversion finished, adc_data valid |
| adc_data | input | DATA_W | Conversion result |
| tx_valid | output | 1 | Outgoing message present |
| tx_ready | input | 1 | Bus side accepts the outgoing message |
| tx_id | output | ID_W | Outgoing identifier |
| tx_data | output | DATA_W | Outgoing payload byte |
| node_active | output | 1 | Node has been activated |
| cool_on | output | 1 | Hysteretic cooling output |

## Verification
The bench builds the block with SAMPLE_TICKS = 16 and ID_BASE = 0x120, and keeps the thresholds at 36 and 31. The short tick period lets each test reading be turned around in about twenty cycles. That makes room for a couple of hundred random readings in the 24 to 43 band, which crosses both thresholds many times, under random tx_ready stalls. Directed steps cover the exact threshold codes (36 does not fire, 31 does not switch off), the priority ordering with a stalled port, and a deactivate/reactivate cycle with a remote request before the first new sample.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
  // message numbers (identifier = base + number - 1)
  localparam int unsigned MSG_WAKE     = 1;
  localparam int unsigned MSG_HOT      = 4;
  localparam int unsigned MSG_COOL_ST  = 5;
  localparam int unsigned MSG_RD_DASH  = 8;
  localparam int unsigned MSG_RD_COOL  = 9;
  localparam int unsigned MSG_SLEEP    = 11;

  // transmit sources, index order is identifier order (priority)
  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned SRC_W   = $clog2(NUM_SRC);
  typedef enum logic [SRC_W-1:0] {
    SRC_HOT  = 2'd0,
    SRC_ST   = 2'd1,
    SRC_DASH = 2'd2,
    SRC_COOL = 2'd3
  } tx_src_e;

  function automatic int unsigned src_msg_num(input tx_src_e s);
    case (s)
      SRC_HOT:  return MSG_HOT;
      SRC_ST:   return MSG_COOL_ST;
      SRC_DASH: return MSG_RD_DASH;
      default:  return MSG_RD_COOL;
    endcase
  endfunction

  typedef enum logic {CV_IDLE = 1'b0, CV_WAIT = 1'b1} conv_state_e;
endpackage

// File: rtl/tmon_rx_decode.sv
module tmon_rx_decode #(
  parameter int unsigned ID_W = 11,
  parameter logic [ID_W-1:0] ID_BASE = 11'h100
) (
  input  logic            rx_valid,
  input  logic [ID_W-1:0] rx_id,
  input  logic            rx_remote,
  input  logic            active,
  output logic            wake_p,
  output logic            sleep_p,
  output logic            hot_rx_p,
  output logic            req_dash_p,
  output logic            req_cool_p
);
  import tmon_pkg::*;

  localparam logic [ID_W-1:0] ID_WAKE  = ID_BASE + ID_W'(MSG_WAKE - 1);
  localparam logic [ID_W-1:0] ID_HOT   = ID_BASE + ID_W'(MSG_HOT - 1);
  localparam logic [ID_W-1:0] ID_DASH  = ID_BASE + ID_W'(MSG_RD_DASH - 1);
  localparam logic [ID_W-1:0] ID_COOL  = ID_BASE + ID_W'(MSG_RD_COOL - 1);
  localparam logic [ID_W-1:0] ID_SLEEP = ID_BASE + ID_W'(MSG_SLEEP - 1);

  logic data_fr, remote_fr, live;

  always_comb begin
    data_fr    = rx_valid && !rx_remote;
    remote_fr  = rx_valid &&  rx_remote;
    wake_p     = data_fr && (rx_id == ID_WAKE) && !active;
    sleep_p    = data_fr && (rx_id == ID_SLEEP) && active;
    live       = active && !sleep_p;
    hot_rx_p   = live && data_fr && (rx_id == ID_HOT);
    req_dash_p = live && remote_fr && (rx_id == ID_DASH);
    req_cool_p = live && remote_fr && (rx_id == ID_COOL);
  end
endmodule

// File: rtl/tmon_sampler.sv
module tmon_sampler #(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned SAMPLE_TICKS = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              kill,
  output logic              adc_start,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  output logic              samp_valid,
  output logic [DATA_W-1:0] samp_code
);
  import tmon_pkg::*;

  localparam int unsigned CNT_W = (SAMPLE_TICKS > 2) ? $clog2(SAMPLE_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_TICKS - 1);

  logic [CNT_W-1:0] tick_cnt;
  conv_state_e      cv_st;
  logic             run;

  assign run = active && !kill;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt   <= '0;
      cv_st      <= CV_IDLE;
      adc_start  <= 1'b0;
      samp_valid <= 1'b0;
      samp_code  <= '0;
    end else begin
      adc_start  <= 1'b0;
      samp_valid <= 1'b0;
      if (!run)                 tick_cnt <= '0;
      else if (tick_cnt == LAST) tick_cnt <= '0;
      else                      tick_cnt <= tick_cnt + 1'b1;
      case (cv_st)
        CV_IDLE: begin
          // a tick that lands on a busy converter is skipped
          if (run && tick_cnt == LAST) begin
            adc_start <= 1'b1;
            cv_st     <= CV_WAIT;
          end
        end
        default: begin
          if (adc_done) begin
            cv_st <= CV_IDLE;
            if (run) begin
              samp_valid <= 1'b1;
              samp_code  <= adc_data;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/tmon_thresh.sv
module tmon_thresh #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ON_CODE  = 36,
  parameter int unsigned OFF_CODE = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kill,
  input  logic              samp_valid,
  input  logic [DATA_W-1:0] samp_code,
  input  logic              hot_rx_p,
  output logic              hot_evt,
  output logic              cool_rise,
  output logic              cool_on,
  output logic [DATA_W-1:0] temp_code
);
  localparam logic [DATA_W-1:0] ON_C  = DATA_W'(ON_CODE);
  localparam logic [DATA_W-1:0] OFF_C = DATA_W'(OFF_CODE);

  logic armed, cool_nx, below_off;

  always_comb begin
    below_off = samp_valid && (samp_code < OFF_C);
    hot_evt   = !kill && samp_valid && armed && (samp_code > ON_C);
    if (kill)                    cool_nx = 1'b0;
    else if (below_off)          cool_nx = 1'b0;
    else if (hot_evt || hot_rx_p) cool_nx = 1'b1;
    else                         cool_nx = cool_on;
    cool_rise = cool_nx && !cool_on;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b1;
      cool_on   <= 1'b0;
      temp_code <= '0;
    end else begin
      cool_on <= cool_nx;
      if (kill) begin
        armed     <= 1'b1;
        temp_code <= '0;
      end else if (samp_valid) begin
        temp_code <= samp_code;
        if (hot_evt)        armed <= 1'b0;
        else if (below_off) armed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmon_tx_arb.sv
module tmon_tx_arb #(
  parameter int unsigned ID_W   = 11,
  parameter int unsigned DATA_W = 8,
  parameter logic [ID_W-1:0] ID_BASE = 11'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kill,
  input  logic              set_hot,
  input  logic              set_st,
  input  logic              set_dash,
  input  logic              set_cool,
  input  logic [DATA_W-1:0] hot_code,
  input  logic [DATA_W-1:0] temp_code,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [ID_W-1:0]   tx_id,
  output logic [DATA_W-1:0] tx_data
);
  import tmon_pkg::*;

  logic [NUM_SRC-1:0] pend, set_v, clr_v;
  logic [DATA_W-1:0]  hot_hold;
  tx_src_e            pick;
  logic               any, load;
  logic [ID_W-1:0]    pick_id;
  logic [DATA_W-1:0]  pick_data;

  assign set_v = {set_cool, set_dash, set_st, set_hot};

  always_comb begin
    pick = SRC_COOL;
    any  = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        pick = tx_src_e'(SRC_W'(i));
        any  = 1'b1;
      end
    end
    load    = any && !kill && (!tx_valid || tx_ready);
    pick_id = ID_BASE + ID_W'(src_msg_num(pick) - 1);
    case (pick)
      SRC_HOT: pick_data = hot_hold;
      SRC_ST:  pick_data = DATA_W'(1);
      default: pick_data = temp_code;
    endcase
  end

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_pend
      assign clr_v[g] = load && (pick == tx_src_e'(SRC_W'(g)));
      always_ff @(posedge clk) begin
        if (!rst_n || kill) pend[g] <= 1'b0;
        else                pend[g] <= (pend[g] && !clr_v[g]) || set_v[g];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hot_hold <= '0;
      tx_valid <= 1'b0;
      tx_id    <= '0;
      tx_data  <= '0;
    end else begin
      if (set_hot) hot_hold <= hot_code;
      if (load) begin
        tx_valid <= 1'b1;
        tx_id    <= pick_id;
        tx_data  <= pick_data;
      end else if (tx_valid && tx_ready) begin
        tx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tmon_node.sv
module tmon_node #(
  parameter int unsigned ID_W         = 11,
  parameter int unsigned DATA_W       = 8,
  parameter logic [ID_W-1:0] ID_BASE  = 11'h100,
  parameter int unsigned SAMPLE_TICKS = 5000,
  parameter int unsigned ON_CODE      = 36,
  parameter int unsigned OFF_CODE     = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [ID_W-1:0]   rx_id,
  input  logic              rx_remote,
  output logic              adc_start,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [ID_W-1:0]   tx_id,
  output logic [DATA_W-1:0] tx_data,
  output logic              node_active,
  output logic              cool_on
);
  logic wake_p, sleep_p, hot_rx_p, req_dash_p, req_cool_p;
  logic samp_valid, hot_evt, cool_rise;
  logic [DATA_W-1:0] samp_code, temp_code;

  assign rx_ready = 1'b1;

  tmon_rx_decode #(.ID_W(ID_W), .ID_BASE(ID_BASE)) u_dec (
    .rx_valid(rx_valid), .rx_id(rx_id), .rx_remote(rx_remote),
    .active(node_active), .wake_p(wake_p), .sleep_p(sleep_p),
    .hot_rx_p(hot_rx_p), .req_dash_p(req_dash_p), .req_cool_p(req_cool_p)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       node_active <= 1'b0;
    else if (wake_p)  node_active <= 1'b1;
    else if (sleep_p) node_active <= 1'b0;
  end

  tmon_sampler #(.DATA_W(DATA_W), .SAMPLE_TICKS(SAMPLE_TICKS)) u_smp (
    .clk(clk), .rst_n(rst_n), .active(node_active), .kill(sleep_p),
    .adc_start(adc_start), .adc_done(adc_done), .adc_data(adc_data),
    .samp_valid(samp_valid), .samp_code(samp_code)
  );

  tmon_thresh #(.DATA_W(DATA_W), .ON_CODE(ON_CODE), .OFF_CODE(OFF_CODE)) u_thr (
    .clk(clk), .rst_n(rst_n), .kill(sleep_p),
    .samp_valid(samp_valid), .samp_code(samp_code), .hot_rx_p(hot_rx_p),
    .hot_evt(hot_evt), .cool_rise(cool_rise), .cool_on(cool_on),
    .temp_code(temp_code)
  );

  tmon_tx_arb #(.ID_W(ID_W), .DATA_W(DATA_W), .ID_BASE(ID_BASE)) u_arb (
    .clk(clk), .rst_n(rst_n), .kill(sleep_p),
    .set_hot(hot_evt), .set_st(cool_rise), .set_dash(req_dash_p),
    .set_cool(req_cool_p), .hot_code(samp_code), .temp_code(temp_code),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_id(tx_id), .tx_data(tx_data)
  );
endmodule

// File: rtl/tmon_node_chk.sv
module tmon_node_chk #(
  parameter int unsigned ID_W         = 11,
  parameter int unsigned DATA_W       = 8,
  parameter logic [ID_W-1:0] ID_BASE  = 11'h100,
  parameter int unsigned SAMPLE_TICKS = 5000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_ready,
  input logic              adc_start,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [ID_W-1:0]   tx_id,
  input logic [DATA_W-1:0] tx_data,
  input logic              node_active,
  input logic              cool_on
);
  localparam int unsigned GAP_W = $clog2(SAMPLE_TICKS + 1) + 1;
  localparam logic [GAP_W-1:0] GAP_MAX = '1;
  localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(SAMPLE_TICKS - 1);

  logic [GAP_W-1:0] gap;
  always_ff @(posedge clk) begin
    if (!rst_n || !node_active || adc_start) gap <= '0;
    else if (gap != GAP_MAX)                 gap <= gap + 1'b1;
  end

  assert_dormant_no_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !node_active |-> !adc_start);
  assert_tx_rise_active_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> node_active);
  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);
  assert_start_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> gap >= GAP_MIN);
  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_id) && $stable(tx_data));
  assert_tx_id_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_id == ID_BASE + ID_W'(3) || tx_id == ID_BASE + ID_W'(4) ||
                  tx_id == ID_BASE + ID_W'(7) || tx_id == ID_BASE + ID_W'(8)));
  assert_cool_needs_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !node_active |-> !cool_on);
  assert_rx_always_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready);
endmodule

bind tmon_node tmon_node_chk #(
  .ID_W(ID_W), .DATA_W(DATA_W), .ID_BASE(ID_BASE), .SAMPLE_TICKS(SAMPLE_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .adc_start(adc_start),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_id(tx_id), .tx_data(tx_data),
  .node_active(node_active), .cool_on(cool_on)
);

// File: tb/tmon_node_tb.sv
module tmon_node_tb;
  localparam int unsigned ID_W = 11, DATA_W = 8, TICKS = 16, ON = 36, OFF = 31, LAT = 3;
  localparam logic [10:0] BASE = 11'h120;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_remote = 1'b0, rx_ready;
  logic [10:0] rx_id = '0;
  logic adc_start, adc_done = 1'b0;
  logic [7:0] adc_data = '0;
  logic tx_valid, tx_ready = 1'b0;
  logic [10:0] tx_id;
  logic [7:0] tx_data;
  logic node_active, cool_on;

  tmon_node #(.ID_W(ID_W), .DATA_W(DATA_W), .ID_BASE(BASE), .SAMPLE_TICKS(TICKS),
              .ON_CODE(ON), .OFF_CODE(OFF)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_id(rx_id), .rx_remote(rx_remote), .adc_start(adc_start),
    .adc_done(adc_done), .adc_data(adc_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_id(tx_id), .tx_data(tx_data),
    .node_active(node_active), .cool_on(cool_on)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int start_cnt = 0, done_cnt = 0, last_start = 0, start_gap = 0, lat_cnt = 0;
  int rdy_mode = 1;
  logic [7:0] cur_adc = '0, conv_val = '0;
  int rec_id[$];
  int rec_dat[$];
  bit finished = 0;

  function automatic int mid(input int n);
    return int'(BASE) + n - 1;
  endfunction

  // ADC model and transmit sink, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    adc_done = 1'b0;
    if (lat_cnt > 0) begin
      lat_cnt--;
      if (lat_cnt == 0) begin
        adc_done = 1'b1;
        adc_data = conv_val;
        done_cnt++;
      end
    end
    if (adc_start) begin
      start_cnt++;
      start_gap  = cyc - last_start;
      last_start = cyc;
      conv_val   = cur_adc;
      lat_cnt    = LAT;
    end
    case (rdy_mode)
      0: tx_ready = 1'b0;
      1: tx_ready = 1'b1;
      default: tx_ready = ($urandom % 3) != 0;
    endcase
    if (tx_valid && tx_ready) begin
      rec_id.push_back(int'(tx_id));
      rec_dat.push_back(int'(tx_data));
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int n, input bit remote);
    @(negedge clk);
    rx_valid = 1'b1; rx_id = 11'(mid(n)); rx_remote = remote;
    @(negedge clk);
    rx_valid = 1'b0; rx_remote = 1'b0;
  endtask

  task automatic do_sample(input logic [7:0] v);
    int s0;
    @(posedge clk);
    cur_adc = v;
    s0 = start_cnt;
    while (start_cnt == s0) @(negedge clk);
    while (done_cnt < start_cnt) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  function automatic int count_id(input int from, input int id);
    int c = 0;
    for (int i = from; i < rec_id.size(); i++) if (rec_id[i] == id) c++;
    return c;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    int base, s0, m_hot, m_st;
    bit m_cool, m_arm;
    logic [7:0] v;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk(tx_valid == 0 && adc_start == 0, "R1 reset tx/adc", int'(tx_valid), 0);
    chk(cool_on == 0 && node_active == 0, "R1 reset cool/active", int'(cool_on), 0);
    chk(rx_ready == 1, "R12 rx_ready", int'(rx_ready), 1);
    rst_n = 1'b1;

    // dormant: everything but activation ignored
    send(8, 1); send(4, 0); send(9, 1); send(11, 0);
    repeat (40) @(negedge clk);
    chk(start_cnt == 0, "R1 no adc start dormant", start_cnt, 0);
    chk(rec_id.size() == 0, "R1 no tx dormant", rec_id.size(), 0);
    chk(cool_on == 0 && node_active == 0, "R1 cool stays off", int'(cool_on), 0);

    send(1, 0);
    repeat (2) @(negedge clk);
    chk(node_active == 1, "R2 activation", int'(node_active), 1);

    do_sample(8'd30); do_sample(8'd30);
    chk(start_gap == TICKS, "R3 start interval", start_gap, TICKS);
    chk(rec_id.size() == 0 && cool_on == 0, "R4 below threshold quiet", rec_id.size(), 0);

    do_sample(8'd37);
    chk(rec_id.size() == 2, "R4 hot crossing sends", rec_id.size(), 2);
    if (rec_id.size() >= 2) begin
      chk(rec_id[0] == mid(4) && rec_dat[0] == 37, "R4 hot msg id/data", rec_id[0], mid(4));
      chk(rec_id[1] == mid(5) && rec_dat[1] == 1, "R5 cool status msg", rec_id[1], mid(5));
    end
    chk(cool_on == 1, "R5 cooling on", int'(cool_on), 1);

    do_sample(8'd40); do_sample(8'd40);
    chk(rec_id.size() == 2, "R4 once per crossing", rec_id.size(), 2);
    do_sample(8'd36); do_sample(8'd31);
    chk(cool_on == 1, "R6 31..36 keeps cooling", int'(cool_on), 1);
    do_sample(8'd37);
    chk(rec_id.size() == 2, "R4 not re-armed at 31", rec_id.size(), 2);
    do_sample(8'd30);
    chk(cool_on == 0, "R6 below off code", int'(cool_on), 0);
    do_sample(8'd37);
    chk(rec_id.size() == 4 && rec_id[2] == mid(4) && rec_dat[2] == 37, "R4 re-armed",
        rec_id.size(), 4);
    do_sample(8'd20);
    chk(cool_on == 0, "R6 off at 20", int'(cool_on), 0);

    base = rec_id.size();
    send(4, 0);
    repeat (6) @(negedge clk);
    chk(cool_on == 1 && count_id(base, mid(5)) == 1, "R5 rx hot frame", int'(cool_on), 1);

    base = rec_id.size();
    send(8, 1);
    repeat (6) @(negedge clk);
    chk(rec_id.size() == base + 1 && rec_id[base] == mid(8) && rec_dat[base] == 20,
        "R7 dashboard reply", rec_id.size() > base ? rec_dat[base] : -1, 20);
    base = rec_id.size();
    send(9, 1);
    repeat (6) @(negedge clk);
    chk(rec_id.size() == base + 1 && rec_id[base] == mid(9) && rec_dat[base] == 20,
        "R8 cooling reply", rec_id.size() > base ? rec_dat[base] : -1, 20);
    base = rec_id.size();
    send(8, 0);
    repeat (6) @(negedge clk);
    chk(rec_id.size() == base, "R7 data frame no reply", rec_id.size(), base);

    // priority under stall
    rdy_mode = 0;
    base = rec_id.size();
    send(9, 1);
    repeat (3) @(negedge clk);
    send(9, 1); send(8, 1);
    repeat (3) @(negedge clk);
    chk(tx_valid == 1 && int'(tx_id) == mid(9), "R9 stalled message held", int'(tx_id), mid(9));
    repeat (5) @(negedge clk);
    chk(tx_valid == 1 && int'(tx_id) == mid(9) && tx_data == 8'd20, "R9 still stable",
        int'(tx_id), mid(9));
    rdy_mode = 1;
    repeat (8) @(negedge clk);
    chk(rec_id.size() == base + 3 && rec_id[base] == mid(9) && rec_id[base+1] == mid(8) &&
        rec_id[base+2] == mid(9), "R10 ascending order",
        rec_id.size() > base + 1 ? rec_id[base+1] : -1, mid(8));

    // deactivate
    send(4, 0);
    repeat (4) @(negedge clk);
    send(11, 0);
    repeat (3) @(negedge clk);
    chk(node_active == 0 && cool_on == 0, "R11 sleep clears", int'(cool_on), 0);
    s0 = start_cnt;
    base = rec_id.size();
    send(8, 1);
    repeat (40) @(negedge clk);
    chk(start_cnt == s0 && rec_id.size() == base, "R11 dormant again", start_cnt - s0, 0);
    send(1, 0);
    repeat (2) @(negedge clk);
    send(8, 1);
    repeat (6) @(negedge clk);
    chk(rec_id.size() == base + 1 && rec_dat[base] == 0, "R11 reading cleared",
        rec_id.size() > base ? rec_dat[base] : -1, 0);

    // random readings with random stalls
    rdy_mode = 2;
    base = rec_id.size();
    m_hot = 0; m_st = 0; m_cool = 0; m_arm = 1;
    for (int k = 0; k < 200; k++) begin
      v = 8'(24 + ($urandom % 20));
      do_sample(v);
      if (v > ON && m_arm) begin
        m_hot++; m_arm = 0;
        if (!m_cool) begin m_st++; m_cool = 1; end
      end else if (v < OFF) begin
        m_cool = 0; m_arm = 1;
      end
      chk(cool_on == m_cool, "R6 random cooling", int'(cool_on), int'(m_cool));
    end
    repeat (30) @(negedge clk);
    chk(count_id(base, mid(4)) == m_hot, "R4 random hot count", count_id(base, mid(4)), m_hot);
    chk(count_id(base, mid(5)) == m_st, "R5 random status count", count_id(base, mid(5)), m_st);

    finished = 1;
    finish_run();
  end
endmodule